// File: doc/BRIEF.md
# CPU and bus clock-enable generator

This block turns one fast reference clock into two clock-enable strobes: one for the CPU and one for the peripheral bus. The reference clock stands in for whichever clock source is selected. A 2-bit source select picks crystal (0), main PLL (1), fast RC oscillator (2) or audio PLL (3). A 2-bit period select and a pre-divider count then set how many reference cycles lie between CPU strobes. The bus strobe is taken from the CPU strobes, and its spacing depends on the source as well as on the CPU ratio. On the main PLL path the bus stays at a fixed rate: every 4 reference cycles with the 320 MHz setting, and every 6 reference cycles in period select 2, where the reference represents the 480 MHz setting.

Configuration inputs are captured in a staging register every cycle. A small controller then moves the staged value into the active configuration only at a CPU strobe boundary. The controller has three states:
- `ST_INIT` is entered by reset. It loads the active configuration and always moves to `ST_RUN` on the next cycle.
- `ST_RUN` moves to `ST_ARMED` when the staged value differs from the active one.
- `ST_ARMED` moves back to `ST_RUN` either on a CPU strobe, where it applies the staged value and restarts both dividers, or when the staged value again equals the active one (cancel, nothing applied).

Status outputs report the active ratios in reference cycles.

Top module: `clktick_gen`

## Requirements
- R1: `src_sel` encoding is 0 crystal, 1 main PLL, 2 fast RC, 3 audio PLL; the encoding alone chooses which ratio rule below applies.
- R2: With crystal or fast RC active, `cpu_tick` repeats every `pre_div`+1 reference cycles, and `bus_tick` is high on every CPU strobe.
- R3: With main PLL active, `cpu_tick` repeats every 4 cycles for `per_sel` 0 and every 2 cycles for `per_sel` 1, 2 and 3; `pre_div` has no effect.
- R4: With main PLL active, `bus_tick` repeats every 4 cycles for `per_sel` 0, 1 and 3, and every 6 cycles for `per_sel` 2.
- R5: With audio PLL active, `cpu_tick` repeats every 4 cycles for `per_sel` 0 and every 2 cycles otherwise, and `bus_tick` falls on every second CPU strobe.
- R6: `bus_tick` is never high without `cpu_tick`. When the CPU ratio exceeds 1, each strobe is high for exactly one cycle.
- R7: Reset is synchronous and active high. While it is applied, both strobes are low. After release, the first `cpu_tick` is seen after D rising edges with reset low, and the first `bus_tick` after D*K edges. D is the CPU ratio and K is the number of CPU strobes per bus strobe.
- R8: A configuration change takes effect only at the next CPU strobe boundary. Until then the strobe spacing and status outputs keep their old values, so the interval that straddles the change has the old length.
- R9: When a new configuration is applied, the bus divider restarts. The next `bus_tick` comes K_new*D_new cycles after the applying CPU strobe. The applying strobe itself still carries the old bus cadence.
- R10: `cpu_ratio` shows D and `bus_ratio` shows D*K of the active configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 2 | Clock source select |
| per_sel | input | 2 | Period select for the PLL paths |
| pre_div | input | PDW | Pre-divider count for crystal and fast RC |
| cpu_tick | output | 1 | CPU clock-enable strobe |
| bus_tick | output | 1 | Peripheral bus clock-enable strobe |
| cpu_ratio | output | PDW+1 | Active reference cycles per CPU strobe |
| bus_ratio | output | PDW+3 | Active reference cycles per bus strobe |

## Verification
A configuration change can be applied on the same CPU strobe on which the old bus cadence fires a bus strobe. The bench provokes this in two ways:
- Switching away from the crystal, where every CPU strobe is a bus strobe.
- Requesting a change just after a non-bus strobe of the audio path, so the applying strobe is the one due to carry a bus pulse.

It judges the result by requiring that the bus pulse is still present on the applying strobe. The restarted bus count must then give the first new bus strobe exactly K_new*D_new cycles later. The spacing of the straddling interval confirms that the request did not shorten the old period.

// File: rtl/clktick_pkg.sv
`timescale 1ns/1ps
package clktick_pkg;

    typedef enum logic [1:0] {
        SRC_XTAL = 2'd0,
        SRC_MPLL = 2'd1,
        SRC_FRC  = 2'd2,
        SRC_APLL = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_ARMED = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/clktick_ratio_calc.sv
`timescale 1ns/1ps
module clktick_ratio_calc
    import clktick_pkg::*;
#(
    parameter int PDW = 8
) (
    input  src_e             src_i,
    input  logic [1:0]       mode_i,
    input  logic [PDW-1:0]   pre_i,
    output logic [PDW:0]     cpu_div_o,
    output logic [1:0]       bus_mult_o
);

    localparam int RW = PDW + 1;

    always_comb begin
        cpu_div_o  = RW'(2);
        bus_mult_o = 2'd1;
        unique case (src_i)
            SRC_XTAL, SRC_FRC: begin
                cpu_div_o  = RW'(pre_i) + RW'(1);
                bus_mult_o = 2'd1;
            end
            SRC_MPLL: begin
                // bus held at a quarter of 320 MHz or a sixth of 480 MHz
                unique case (mode_i)
                    2'd0: begin cpu_div_o = RW'(4); bus_mult_o = 2'd1; end
                    2'd2: begin cpu_div_o = RW'(2); bus_mult_o = 2'd3; end
                    default: begin cpu_div_o = RW'(2); bus_mult_o = 2'd2; end
                endcase
            end
            SRC_APLL: begin
                cpu_div_o  = (mode_i == 2'd0) ? RW'(4) : RW'(2);
                bus_mult_o = 2'd2;
            end
        endcase
    end

endmodule

// File: rtl/clktick_cfg_ctrl.sv
`timescale 1ns/1ps
module clktick_cfg_ctrl
    import clktick_pkg::*;
#(
    parameter int PDW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     src_i,
    input  logic [1:0]     mode_i,
    input  logic [PDW-1:0] pre_i,
    input  logic           tick_i,
    output logic           run_o,
    output logic           apply_o,
    output src_e           act_src_o,
    output logic [1:0]     act_mode_o,
    output logic [PDW-1:0] act_pre_o
);

    ctl_state_e     state_q, state_d;
    logic [1:0]     stg_src_q, stg_mode_q;
    logic [PDW-1:0] stg_pre_q;
    logic [1:0]     act_src_q, act_mode_q;
    logic [PDW-1:0] act_pre_q;
    logic           differs;
    logic           load;

    assign differs = (stg_src_q != act_src_q) || (stg_mode_q != act_mode_q) ||
                     (stg_pre_q != act_pre_q);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_INIT;
        else     state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        apply_o = 1'b0;
        run_o   = 1'b1;
        load    = 1'b0;
        unique case (state_q)
            ST_INIT: begin
                run_o   = 1'b0;
                load    = 1'b1;
                state_d = ST_RUN;
            end
            ST_RUN: begin
                if (differs) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!differs) begin
                    state_d = ST_RUN;
                end else if (tick_i) begin
                    apply_o = 1'b1;
                    load    = 1'b1;
                    state_d = ST_RUN;
                end
            end
            default: begin
                run_o   = 1'b0;
                state_d = ST_INIT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        stg_src_q  <= src_i;
        stg_mode_q <= mode_i;
        stg_pre_q  <= pre_i;
        if (rst) begin
            act_src_q  <= '0;
            act_mode_q <= '0;
            act_pre_q  <= '0;
        end else if (load) begin
            act_src_q  <= stg_src_q;
            act_mode_q <= stg_mode_q;
            act_pre_q  <= stg_pre_q;
        end
    end

    assign act_src_o  = src_e'(act_src_q);
    assign act_mode_o = act_mode_q;
    assign act_pre_o  = act_pre_q;

    // R8: active configuration only moves on a CPU strobe once running
    a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_INIT && !tick_i) |=>
            ($stable(act_src_q) && $stable(act_mode_q) && $stable(act_pre_q)));

    // R7: the load state lasts a single cycle
    a_r7_init_leaves: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_INIT) |=> (state_q == ST_RUN));

endmodule

// File: rtl/clktick_div_core.sv
`timescale 1ns/1ps
module clktick_div_core #(
    parameter int PDW = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_i,
    input  logic         restart_i,
    input  logic [PDW:0] div_i,
    input  logic [1:0]   mult_i,
    output logic         cpu_tick_o,
    output logic         bus_tick_o
);

    localparam int RW = PDW + 1;

    logic [RW-1:0] cnt_q;
    logic [1:0]    bus_cnt_q;

    assign cpu_tick_o = run_i && (cnt_q == div_i - RW'(1));
    assign bus_tick_o = cpu_tick_o && (bus_cnt_q == mult_i - 2'd1);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q     <= '0;
            bus_cnt_q <= '0;
        end else if (cpu_tick_o) begin
            cnt_q <= '0;
            if (restart_i)
                bus_cnt_q <= '0;
            else if (bus_cnt_q == mult_i - 2'd1)
                bus_cnt_q <= '0;
            else
                bus_cnt_q <= bus_cnt_q + 2'd1;
        end else begin
            cnt_q <= cnt_q + RW'(1);
        end
    end

    // R2: CPU counter stays inside the active period
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt_q < div_i));

    // R6: strobe lasts one cycle when the ratio exceeds one
    a_r6_cpu_single: assert property (@(posedge clk) disable iff (rst)
        (cpu_tick_o && div_i != RW'(1) && !restart_i) |=> !cpu_tick_o);

    // R9: applying a configuration restarts the bus count
    a_r9_bus_restart: assert property (@(posedge clk) disable iff (rst)
        (cpu_tick_o && restart_i) |=> (bus_cnt_q == 2'd0));

endmodule

// File: rtl/clktick_gen.sv
`timescale 1ns/1ps
module clktick_gen
    import clktick_pkg::*;
#(
    parameter int PDW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     src_sel,
    input  logic [1:0]     per_sel,
    input  logic [PDW-1:0] pre_div,
    output logic           cpu_tick,
    output logic           bus_tick,
    output logic [PDW:0]   cpu_ratio,
    output logic [PDW+2:0] bus_ratio
);

    localparam int RW  = PDW + 1;
    localparam int BRW = RW + 2;

    logic           run;
    logic           apply;
    src_e           act_src;
    logic [1:0]     act_mode;
    logic [PDW-1:0] act_pre;
    logic [RW-1:0]  cpu_div;
    logic [1:0]     bus_mult;

    clktick_cfg_ctrl #(.PDW(PDW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src_sel),
        .mode_i    (per_sel),
        .pre_i     (pre_div),
        .tick_i    (cpu_tick),
        .run_o     (run),
        .apply_o   (apply),
        .act_src_o (act_src),
        .act_mode_o(act_mode),
        .act_pre_o (act_pre)
    );

    clktick_ratio_calc #(.PDW(PDW)) u_ratio (
        .src_i     (act_src),
        .mode_i    (act_mode),
        .pre_i     (act_pre),
        .cpu_div_o (cpu_div),
        .bus_mult_o(bus_mult)
    );

    clktick_div_core #(.PDW(PDW)) u_core (
        .clk       (clk),
        .rst       (rst),
        .run_i     (run),
        .restart_i (apply),
        .div_i     (cpu_div),
        .mult_i    (bus_mult),
        .cpu_tick_o(cpu_tick),
        .bus_tick_o(bus_tick)
    );

    assign cpu_ratio = cpu_div;
    assign bus_ratio = BRW'(cpu_div) * BRW'(bus_mult);

    // R6: a bus strobe always rides on a CPU strobe
    a_r6_bus_within_cpu: assert property (@(posedge clk) disable iff (rst)
        bus_tick |-> cpu_tick);

endmodule

// File: tb/clktick_gen_test.sv
`timescale 1ns/1ps
module clktick_gen_test;

    localparam int PDW = 8;
    localparam int NV  = 12;
    // columns: src, per, pre, expected D, expected K
    localparam int VEC [0:NV-1][0:4] = '{
        '{0, 0,   0, 1,   1},
        '{0, 3,   4, 5,   1},
        '{2, 1,   2, 3,   1},
        '{2, 0,   7, 8,   1},
        '{1, 0,   9, 4,   1},
        '{1, 1,   3, 2,   2},
        '{1, 2,   0, 2,   3},
        '{1, 3,   5, 2,   2},
        '{3, 0,   6, 4,   2},
        '{3, 1,   0, 2,   2},
        '{3, 2,   1, 2,   2},
        '{0, 0, 255, 256, 1}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [1:0]     src_sel = 2'd0;
    logic [1:0]     per_sel = 2'd0;
    logic [PDW-1:0] pre_div = '0;
    logic           cpu_tick, bus_tick;
    logic [PDW:0]   cpu_ratio;
    logic [PDW+2:0] bus_ratio;

    int errs   = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    clktick_gen #(.PDW(PDW)) uut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .per_sel(per_sel),
        .pre_div(pre_div), .cpu_tick(cpu_tick), .bus_tick(bus_tick),
        .cpu_ratio(cpu_ratio), .bus_ratio(bus_ratio)
    );

    task automatic chk(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic gap_to_cpu(output int g);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!cpu_tick && g < 2000);
    endtask

    task automatic do_reset(input int s, input int m, input int p);
        @(negedge clk);
        src_sel = 2'(s); per_sel = 2'(m); pre_div = PDW'(p);
        rst = 1'b1;
        @(negedge clk);
        chk("R7 cpu strobe low in reset", int'(cpu_tick), 0);
        chk("R7 bus strobe low in reset", int'(bus_tick), 0);
        rst = 1'b0;
    endtask

    initial begin
        #500000;
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int g;
        // table walk: one reset per configuration
        for (int i = 0; i < NV; i++) begin
            int d, k, n, ncpu, nbus, cf, c2, bf, b2, viol, dbl;
            string tag;
            d = VEC[i][3]; k = VEC[i][4];
            case (VEC[i][0])
                0, 2:    tag = "R2";
                1:       tag = "R3/R4";
                default: tag = "R5";
            endcase
            do_reset(VEC[i][0], VEC[i][1], VEC[i][2]);
            n = 0; ncpu = 0; nbus = 0; cf = 0; c2 = 0; bf = 0; b2 = 0;
            viol = 0; dbl = 0;
            while (nbus < 2 && n < 2000) begin
                logic prev;
                prev = cpu_tick;
                @(negedge clk);
                n++;
                if (bus_tick && !cpu_tick) viol++;
                if (d > 1 && prev && cpu_tick && n > 1) dbl++;
                if (cpu_tick) begin
                    ncpu++;
                    if (ncpu == 1) cf = n;
                    if (ncpu == 2) c2 = n;
                end
                if (bus_tick) begin
                    nbus++;
                    if (nbus == 1) bf = n;
                    if (nbus == 2) b2 = n;
                end
            end
            chk($sformatf("R7 %s vec%0d first cpu strobe", tag, i), cf, d);
            chk($sformatf("R1 %s vec%0d cpu spacing", tag, i), c2 - cf, d);
            chk($sformatf("R7 %s vec%0d first bus strobe", tag, i), bf, d * k);
            chk($sformatf("%s vec%0d bus spacing", tag, i), b2 - bf, d * k);
            chk($sformatf("R10 vec%0d cpu_ratio", i), int'(cpu_ratio), d);
            chk($sformatf("R10 vec%0d bus_ratio", i), int'(bus_ratio), d * k);
            chk($sformatf("R6 vec%0d bus without cpu", i), viol, 0);
            chk($sformatf("R6 vec%0d strobe wider than one cycle", i), dbl, 0);
        end

        // directed: live switch crystal /5 -> audio PLL /2
        do_reset(0, 3, 4);
        gap_to_cpu(g);
        gap_to_cpu(g);
        chk("R2 crystal spacing before switch", g, 5);
        src_sel = 2'd3; per_sel = 2'd1; pre_div = '0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 ratio held before boundary", int'(cpu_ratio), 5);
        gap_to_cpu(g);
        chk("R8 straddling interval keeps old length", g + 2, 5);
        chk("R9 applying strobe keeps old bus pulse", int'(bus_tick), 1);
        gap_to_cpu(g);
        chk("R8 new spacing after boundary", g, 2);
        chk("R9 no bus on first new strobe", int'(bus_tick), 0);
        gap_to_cpu(g);
        chk("R5 audio spacing", g, 2);
        chk("R9 bus strobe 4 cycles after apply", int'(bus_tick), 1);
        chk("R10 cpu_ratio after switch", int'(cpu_ratio), 2);
        chk("R10 bus_ratio after switch", int'(bus_ratio), 4);
        gap_to_cpu(g);
        chk("R5 every second strobe only", int'(bus_tick), 0);

        // directed: audio -> main PLL period 2, apply on an old bus strobe
        src_sel = 2'd1; per_sel = 2'd2;
        gap_to_cpu(g);
        chk("R8 straddle spacing", g, 2);
        chk("R9 applying strobe carries old cadence", int'(bus_tick), 1);
        gap_to_cpu(g);
        chk("R9 restarted count, strobe 1", int'(bus_tick), 0);
        gap_to_cpu(g);
        chk("R9 restarted count, strobe 2", int'(bus_tick), 0);
        gap_to_cpu(g);
        chk("R4 bus strobe six cycles after apply", int'(bus_tick), 1);
        chk("R4 bus_ratio on 480 setting", int'(bus_ratio), 6);
        chk("R3 cpu_ratio on 480 setting", int'(cpu_ratio), 2);

        // reset in the middle of running
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R7 cpu strobe low during mid-run reset", int'(cpu_tick), 0);
        @(negedge clk);
        chk("R7 bus strobe low during mid-run reset", int'(bus_tick), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule